// File: doc/BRIEF.md
# Store Queue with Load Forwarding

The block holds in-flight stores in a circular buffer. Each store carries its address, its byte size, up to sixteen data bytes, a sequence number and three status flags. Stores enter at the tail. Address and data are filled in later by index, and commit is also marked by index. A writeback pointer hands committed stores to memory in program order. A completed store is released from the head one cycle after it writes back. One slot always stays empty, so that head and tail never coincide while the buffer holds entries.

Each cycle, at most one load may be presented with its address, its size, and the store index it captured at dispatch. The block scans the older stores, youngest first, down to the writeback pointer. The first store whose bytes overlap the load decides the outcome:
- If that store fully contains the load, the block returns the load's bytes from the store data (a forward).
- If the overlap is only partial, the block reports a stall.
- If no store overlaps, the load goes to memory (a miss).

The result is registered one cycle after the request.

A partial overlap also arms a single stall record: the blocking store's sequence number and the stalled load's queue index. When that store writes back, the record clears and a one-cycle replay pulse tells the load pipeline to reissue the load.

Top module: `sqf_store_queue`

## Requirements
- R1: `sq_full` is high whenever occupancy (`sq_count`) is at least SLOTS-1, and occupancy never exceeds SLOTS-1. An enqueue while full is ignored: `enq_idx` and `sq_count` are unchanged.
- R2: An accepted enqueue places the store at `enq_idx` (the tail) and raises `sq_count` by one. The tail then advances by one modulo SLOTS.
- R3: A load considers only the slots from the writeback pointer up to `ld_sq_idx`-1, wrapping modulo SLOTS. If `ld_sq_idx` equals the writeback pointer, no slot is considered. Among overlapping slots, the one nearest `ld_sq_idx` alone decides the result.
- R4: Slots whose recorded size is zero, or that are marked uncacheable, are passed over by the search.
- R5: A store fully contains the load when `ld_addr` >= store address and `ld_addr`+`ld_size` <= store address + store size. The result is then code 2'd1. Result byte k, for k < `ld_size`, is store data byte (offset + k), where offset = `ld_addr` AND (store size - 1). Bytes at and above `ld_size` are zero.
- R6: A store whose byte range intersects the load without containing it gives code 2'd2. No overlapping store gives code 2'd0. In both cases `res_data` is zero.
- R7: `res_valid` is high exactly in the cycle after a cycle with `ld_valid` high.
- R8: A code 2'd2 result sets `stall_active` and records the store's sequence number and `ld_lq_idx`. This happens only if no stall was active, or if `ld_seq` is smaller than that of the load already recorded.
- R9: `wb_addr`, `wb_size` and `wb_data` show the slot at the writeback pointer. `wb_go` while `wb_ready` is high marks that slot completed and moves the pointer one slot younger.
- R10: When the written-back store's sequence number equals `stall_store_seq` while a stall is active, the next cycle shows `stall_active` low and `replay` high for one cycle.
- R11: A completed slot at the head is released the cycle after its writeback, lowering `sq_count` by one.
- R12: `wb_ready` is high only when the slot at the writeback pointer is occupied, has been committed through `cmt_valid`/`cmt_idx`, and has not yet completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Allocate a store slot at the tail |
| enq_seq | input | SEQ_W | Sequence number of the new store |
| enq_idx | output | IDX_W | Slot the next enqueue receives (tail) |
| sq_full | output | 1 | Occupancy at or above SLOTS-1 |
| sq_count | output | IDX_W+1 | Occupied slots |
| wr_valid | input | 1 | Record address and data into a slot |
| wr_idx | input | IDX_W | Slot written |
| wr_addr | input | ADDR_W | Store start address |
| wr_size | input | $clog2(DATA_BYTES)+1 | Store size in bytes |
| wr_uncached | input | 1 | Store is uncacheable |
| wr_data | input | 8*DATA_BYTES | Store data, byte 0 lowest |
| cmt_valid | input | 1 | Mark a slot committed |
| cmt_idx | input | IDX_W | Slot committed |
| wb_go | input | 1 | Memory accepts the store at the writeback pointer |
| wb_ready | output | 1 | A committed store waits at the writeback pointer |
| wb_addr | output | ADDR_W | Address of that store |
| wb_size | output | $clog2(DATA_BYTES)+1 | Size of that store |
| wb_data | output | 8*DATA_BYTES | Data of that store |
| ld_valid | input | 1 | Forwarding lookup request |
| ld_addr | input | ADDR_W | Load start address |
| ld_size | input | $clog2(DATA_BYTES)+1 | Load size in bytes |
| ld_sq_idx | input | IDX_W | Store tail captured at load dispatch |
| ld_lq_idx | input | LQ_IDX_W | Load queue index of the load |
| ld_seq | input | SEQ_W | Load sequence number |
| res_valid | output | 1 | Lookup result strobe |
| res_code | output | 2 | 0 miss, 1 forward, 2 stall |
| res_data | output | 8*DATA_BYTES | Forwarded bytes |
| stall_active | output | 1 | A partial-overlap stall is recorded |
| stall_store_seq | output | SEQ_W | Sequence number of the blocking store |
| stall_load_idx | output | LQ_IDX_W | Load queue index of the stalled load |
| replay | output | 1 | One-cycle pulse when the blocking store completes |

## Verification
The properties take for granted that loads have a nonzero size and that `ld_sq_idx` was a real tail value, so it lies between the writeback pointer and the tail. They also assume writes and commits target occupied slots, and that a new partial stall and the release of the recorded store never fall in the same cycle. The stimulus keeps to this. Every load index handed in is a tail observed from `enq_idx`, and every write and commit uses a slot returned by an enqueue. The overlap sweep drives one store at a time, at an aligned address and with a fixed load sequence number. The stall-clear sequence is driven only after the last partial lookup has settled.

// File: rtl/sqf_pkg.sv
package sqf_pkg;
   localparam logic [1:0] LK_MISS  = 2'd0;
   localparam logic [1:0] LK_FWD   = 2'd1;
   localparam logic [1:0] LK_STALL = 2'd2;
endpackage

// File: rtl/sqf_ring.sv
module sqf_ring #(
   parameter int SLOTS = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       enq_req,
   input  logic                       wb_fire,
   input  logic                       head_done,
   output logic [$clog2(SLOTS)-1:0]   head,
   output logic [$clog2(SLOTS)-1:0]   wbp,
   output logic [$clog2(SLOTS)-1:0]   tail,
   output logic [$clog2(SLOTS):0]     count,
   output logic                       full,
   output logic                       enq_fire,
   output logic                       free_fire
);
   localparam int IDX_W = $clog2(SLOTS);
   localparam int CNT_W = IDX_W + 1;

   assign full      = count >= CNT_W'(SLOTS - 1);
   assign enq_fire  = enq_req && !full;
   assign free_fire = head_done && (head != wbp);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         wbp   <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (enq_fire)  tail <= tail + IDX_W'(1);
         if (wb_fire)   wbp  <= wbp + IDX_W'(1);
         if (free_fire) head <= head + IDX_W'(1);
         case ({enq_fire, free_fire})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/sqf_store_array.sv
module sqf_store_array #(
   parameter int SLOTS      = 8,
   parameter int ADDR_W     = 32,
   parameter int SEQ_W      = 16,
   parameter int DATA_BYTES = 16
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              enq_fire,
   input  logic [$clog2(SLOTS)-1:0]          tail,
   input  logic [SEQ_W-1:0]                  enq_seq,
   input  logic                              wr_valid,
   input  logic [$clog2(SLOTS)-1:0]          wr_idx,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [$clog2(DATA_BYTES):0]       wr_size,
   input  logic                              wr_unc,
   input  logic [8*DATA_BYTES-1:0]           wr_data,
   input  logic                              cmt_valid,
   input  logic [$clog2(SLOTS)-1:0]          cmt_idx,
   input  logic                              wb_fire,
   input  logic [$clog2(SLOTS)-1:0]          wbp,
   input  logic                              free_fire,
   input  logic [$clog2(SLOTS)-1:0]          head,
   output logic [ADDR_W-1:0]                 e_addr [SLOTS],
   output logic [$clog2(DATA_BYTES):0]       e_size [SLOTS],
   output logic                              e_unc  [SLOTS],
   output logic [8*DATA_BYTES-1:0]           e_data [SLOTS],
   output logic [SEQ_W-1:0]                  e_seq  [SLOTS],
   output logic                              e_canwb[SLOTS],
   output logic                              e_cmt  [SLOTS],
   output logic                              e_done [SLOTS]
);
   localparam int IDX_W = $clog2(SLOTS);

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      localparam logic [IDX_W-1:0] ME = IDX_W'(i);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            e_addr[i]  <= '0;
            e_size[i]  <= '0;
            e_unc[i]   <= 1'b0;
            e_data[i]  <= '0;
            e_seq[i]   <= '0;
            e_canwb[i] <= 1'b0;
            e_cmt[i]   <= 1'b0;
            e_done[i]  <= 1'b0;
         end else if (enq_fire && tail == ME) begin
            e_seq[i]   <= enq_seq;
            e_size[i]  <= '0;
            e_unc[i]   <= 1'b0;
            e_canwb[i] <= 1'b0;
            e_cmt[i]   <= 1'b0;
            e_done[i]  <= 1'b0;
         end else begin
            if (wr_valid && wr_idx == ME) begin
               e_addr[i] <= wr_addr;
               e_size[i] <= wr_size;
               e_unc[i]  <= wr_unc;
               e_data[i] <= wr_data;
            end
            if (cmt_valid && cmt_idx == ME) begin
               e_cmt[i]   <= 1'b1;
               e_canwb[i] <= 1'b1;
            end
            if (wb_fire && wbp == ME)
               e_done[i] <= 1'b1;
            if (free_fire && head == ME) begin
               e_canwb[i] <= 1'b0;
               e_cmt[i]   <= 1'b0;
               e_done[i]  <= 1'b0;
               e_size[i]  <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/sqf_fwd_search.sv
module sqf_fwd_search
   import sqf_pkg::*;
#(
   parameter int SLOTS      = 8,
   parameter int ADDR_W     = 32,
   parameter int SEQ_W      = 16,
   parameter int DATA_BYTES = 16,
   parameter bit ZERO_FILL  = 1'b1
) (
   input  logic [ADDR_W-1:0]            ld_addr,
   input  logic [$clog2(DATA_BYTES):0]  ld_size,
   input  logic [$clog2(SLOTS)-1:0]     ld_sq_idx,
   input  logic [$clog2(SLOTS)-1:0]     wbp,
   input  logic [ADDR_W-1:0]            e_addr [SLOTS],
   input  logic [$clog2(DATA_BYTES):0]  e_size [SLOTS],
   input  logic                         e_unc  [SLOTS],
   input  logic [8*DATA_BYTES-1:0]      e_data [SLOTS],
   input  logic [SEQ_W-1:0]             e_seq  [SLOTS],
   output logic [1:0]                   hit_code,
   output logic [8*DATA_BYTES-1:0]      hit_data,
   output logic [SEQ_W-1:0]             hit_seq
);
   localparam int IDX_W  = $clog2(SLOTS);
   localparam int OFF_W  = $clog2(DATA_BYTES);
   localparam int SIZE_W = OFF_W + 1;
   localparam int DW     = 8 * DATA_BYTES;

   logic [ADDR_W:0]     l_lo, l_hi;
   logic                elig [SLOTS];
   logic                ovl  [SLOTS];
   logic                cont [SLOTS];
   logic [IDX_W-1:0]    cand [SLOTS];
   logic [IDX_W-1:0]    span;
   logic                found, is_full;
   logic [IDX_W-1:0]    sel;
   logic [SIZE_W-1:0]   sz_m1;
   logic [OFF_W-1:0]    off;
   logic [DW-1:0]       shifted, fwd_data;
   logic [DATA_BYTES-1:0] keep;

   assign l_lo = {1'b0, ld_addr};
   assign l_hi = l_lo + (ADDR_W+1)'(ld_size);
   assign span = ld_sq_idx - wbp;

   for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
      logic [ADDR_W:0] s_lo, s_hi;
      assign s_lo    = {1'b0, e_addr[i]};
      assign s_hi    = s_lo + (ADDR_W+1)'(e_size[i]);
      assign elig[i] = (e_size[i] != '0) && !e_unc[i];
      assign cont[i] = (l_lo >= s_lo) && (l_hi <= s_hi);
      assign ovl[i]  = (l_lo < s_hi) && (l_hi > s_lo);
   end

   for (genvar d = 0; d < SLOTS; d++) begin : g_age
      assign cand[d] = ld_sq_idx - IDX_W'(d + 1);
   end

   always_comb begin
      found   = 1'b0;
      is_full = 1'b0;
      sel     = '0;
      for (int d = 0; d < SLOTS; d++) begin
         if (!found && (d < int'(span)) && elig[cand[d]] && ovl[cand[d]]) begin
            found   = 1'b1;
            sel     = cand[d];
            is_full = cont[cand[d]];
         end
      end
   end

   assign sz_m1   = e_size[sel] - SIZE_W'(1);
   assign off     = ld_addr[OFF_W-1:0] & sz_m1[OFF_W-1:0];
   assign shifted = e_data[sel] >> {off, 3'b000};

   for (genvar b = 0; b < DATA_BYTES; b++) begin : g_keep
      assign keep[b] = SIZE_W'(b) < ld_size;
   end

   if (ZERO_FILL) begin : g_zero_fill
      for (genvar b = 0; b < DATA_BYTES; b++) begin : g_byte
         assign fwd_data[b*8 +: 8] = keep[b] ? shifted[b*8 +: 8] : 8'h00;
      end
   end else begin : g_raw
      assign fwd_data = shifted;
   end

   assign hit_code = !found ? LK_MISS : (is_full ? LK_FWD : LK_STALL);
   assign hit_data = (found && is_full) ? fwd_data : '0;
   assign hit_seq  = e_seq[sel];
endmodule

// File: rtl/sqf_stall_track.sv
module sqf_stall_track #(
   parameter int SEQ_W    = 16,
   parameter int LQ_IDX_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 part_hit,
   input  logic [SEQ_W-1:0]     part_store_seq,
   input  logic [LQ_IDX_W-1:0]  part_lq_idx,
   input  logic [SEQ_W-1:0]     part_ld_seq,
   input  logic                 wb_fire,
   input  logic [SEQ_W-1:0]     wb_seq,
   output logic                 active,
   output logic [SEQ_W-1:0]     store_seq,
   output logic [LQ_IDX_W-1:0]  load_idx,
   output logic                 replay
);
   logic [SEQ_W-1:0] load_seq;
   logic             take, release_hit;

   assign take        = part_hit && (!active || (part_ld_seq < load_seq));
   assign release_hit = wb_fire && active && (wb_seq == store_seq);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active    <= 1'b0;
         store_seq <= '0;
         load_idx  <= '0;
         load_seq  <= '0;
         replay    <= 1'b0;
      end else begin
         replay <= release_hit;
         if (take) begin
            active    <= 1'b1;
            store_seq <= part_store_seq;
            load_idx  <= part_lq_idx;
            load_seq  <= part_ld_seq;
         end else if (release_hit) begin
            active <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sqf_store_queue.sv
module sqf_store_queue
   import sqf_pkg::*;
#(
   parameter int SLOTS      = 8,
   parameter int ADDR_W     = 32,
   parameter int SEQ_W      = 16,
   parameter int DATA_BYTES = 16,
   parameter int LQ_IDX_W   = 5,
   parameter bit ZERO_FILL  = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              enq_valid,
   input  logic [SEQ_W-1:0]                  enq_seq,
   output logic [$clog2(SLOTS)-1:0]          enq_idx,
   output logic                              sq_full,
   output logic [$clog2(SLOTS):0]            sq_count,
   input  logic                              wr_valid,
   input  logic [$clog2(SLOTS)-1:0]          wr_idx,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [$clog2(DATA_BYTES):0]       wr_size,
   input  logic                              wr_uncached,
   input  logic [8*DATA_BYTES-1:0]           wr_data,
   input  logic                              cmt_valid,
   input  logic [$clog2(SLOTS)-1:0]          cmt_idx,
   input  logic                              wb_go,
   output logic                              wb_ready,
   output logic [ADDR_W-1:0]                 wb_addr,
   output logic [$clog2(DATA_BYTES):0]       wb_size,
   output logic [8*DATA_BYTES-1:0]           wb_data,
   input  logic                              ld_valid,
   input  logic [ADDR_W-1:0]                 ld_addr,
   input  logic [$clog2(DATA_BYTES):0]       ld_size,
   input  logic [$clog2(SLOTS)-1:0]          ld_sq_idx,
   input  logic [LQ_IDX_W-1:0]               ld_lq_idx,
   input  logic [SEQ_W-1:0]                  ld_seq,
   output logic                              res_valid,
   output logic [1:0]                        res_code,
   output logic [8*DATA_BYTES-1:0]           res_data,
   output logic                              stall_active,
   output logic [SEQ_W-1:0]                  stall_store_seq,
   output logic [LQ_IDX_W-1:0]               stall_load_idx,
   output logic                              replay
);
   localparam int IDX_W  = $clog2(SLOTS);
   localparam int SIZE_W = $clog2(DATA_BYTES) + 1;
   localparam int DW     = 8 * DATA_BYTES;

   if (SLOTS < 4 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots
      $error("SLOTS must be a power of two of at least 4");
   end
   if (DATA_BYTES < 2 || (DATA_BYTES & (DATA_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("DATA_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W < SIZE_W || SEQ_W < 1 || LQ_IDX_W < 1) begin : g_bad_widths
      $error("ADDR_W, SEQ_W or LQ_IDX_W out of range");
   end

   logic [IDX_W-1:0]  head, wbp, tail;
   logic              enq_fire, free_fire, wb_fire;
   logic [ADDR_W-1:0] e_addr  [SLOTS];
   logic [SIZE_W-1:0] e_size  [SLOTS];
   logic              e_unc   [SLOTS];
   logic [DW-1:0]     e_data  [SLOTS];
   logic [SEQ_W-1:0]  e_seq   [SLOTS];
   logic              e_canwb [SLOTS];
   logic              e_cmt   [SLOTS];
   logic              e_done  [SLOTS];
   logic [1:0]        hit_code;
   logic [DW-1:0]     hit_data;
   logic [SEQ_W-1:0]  hit_seq;

   sqf_ring #(.SLOTS(SLOTS)) u_ring (
      .clk(clk), .rst_n(rst_n), .enq_req(enq_valid), .wb_fire(wb_fire),
      .head_done(e_done[head]), .head(head), .wbp(wbp), .tail(tail),
      .count(sq_count), .full(sq_full), .enq_fire(enq_fire),
      .free_fire(free_fire)
   );

   sqf_store_array #(
      .SLOTS(SLOTS), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .DATA_BYTES(DATA_BYTES)
   ) u_array (
      .clk(clk), .rst_n(rst_n), .enq_fire(enq_fire), .tail(tail),
      .enq_seq(enq_seq), .wr_valid(wr_valid), .wr_idx(wr_idx),
      .wr_addr(wr_addr), .wr_size(wr_size), .wr_unc(wr_uncached),
      .wr_data(wr_data), .cmt_valid(cmt_valid), .cmt_idx(cmt_idx),
      .wb_fire(wb_fire), .wbp(wbp), .free_fire(free_fire), .head(head),
      .e_addr(e_addr), .e_size(e_size), .e_unc(e_unc), .e_data(e_data),
      .e_seq(e_seq), .e_canwb(e_canwb), .e_cmt(e_cmt), .e_done(e_done)
   );

   sqf_fwd_search #(
      .SLOTS(SLOTS), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W),
      .DATA_BYTES(DATA_BYTES), .ZERO_FILL(ZERO_FILL)
   ) u_search (
      .ld_addr(ld_addr), .ld_size(ld_size), .ld_sq_idx(ld_sq_idx),
      .wbp(wbp), .e_addr(e_addr), .e_size(e_size), .e_unc(e_unc),
      .e_data(e_data), .e_seq(e_seq), .hit_code(hit_code),
      .hit_data(hit_data), .hit_seq(hit_seq)
   );

   sqf_stall_track #(.SEQ_W(SEQ_W), .LQ_IDX_W(LQ_IDX_W)) u_stall (
      .clk(clk), .rst_n(rst_n),
      .part_hit(ld_valid && hit_code == LK_STALL),
      .part_store_seq(hit_seq), .part_lq_idx(ld_lq_idx),
      .part_ld_seq(ld_seq), .wb_fire(wb_fire), .wb_seq(e_seq[wbp]),
      .active(stall_active), .store_seq(stall_store_seq),
      .load_idx(stall_load_idx), .replay(replay)
   );

   assign enq_idx  = tail;
   assign wb_ready = (wbp != tail) && e_canwb[wbp] && e_cmt[wbp] && !e_done[wbp];
   assign wb_fire  = wb_go && wb_ready;
   assign wb_addr  = e_addr[wbp];
   assign wb_size  = e_size[wbp];
   assign wb_data  = e_data[wbp];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_code  <= LK_MISS;
         res_data  <= '0;
      end else begin
         res_valid <= ld_valid;
         res_code  <= ld_valid ? hit_code : LK_MISS;
         res_data  <= ld_valid ? hit_data : '0;
      end
   end
endmodule

// File: rtl/sqf_store_queue_chk.sv
module sqf_store_queue_chk #(
   parameter int SLOTS      = 8,
   parameter int SEQ_W      = 16,
   parameter int DATA_BYTES = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         enq_valid,
   input logic [$clog2(SLOTS)-1:0]     enq_idx,
   input logic                         sq_full,
   input logic [$clog2(SLOTS):0]       sq_count,
   input logic                         ld_valid,
   input logic                         res_valid,
   input logic [1:0]                   res_code,
   input logic [8*DATA_BYTES-1:0]      res_data,
   input logic                         stall_active,
   input logic                         replay
);
   localparam int IDX_W = $clog2(SLOTS);
   localparam int CNT_W = IDX_W + 1;

   p_occupancy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sq_count <= CNT_W'(SLOTS - 1));

   p_full_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_count >= CNT_W'(SLOTS - 1)) |-> sq_full);

   p_full_holds_tail_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_full && enq_valid) |=> (enq_idx == $past(enq_idx)));

   p_tail_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && !sq_full) |=> (enq_idx == IDX_W'($past(enq_idx) + IDX_W'(1))));

   p_result_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |=> res_valid);

   p_no_spurious_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |=> !res_valid);

   p_no_data_unless_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code != 2'd1) |-> (res_data == '0));

   p_stall_recorded_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_code == 2'd2) |-> stall_active);

   p_replay_after_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      replay |-> $past(stall_active));
endmodule

bind sqf_store_queue sqf_store_queue_chk #(
   .SLOTS(SLOTS), .SEQ_W(SEQ_W), .DATA_BYTES(DATA_BYTES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_idx(enq_idx),
   .sq_full(sq_full), .sq_count(sq_count), .ld_valid(ld_valid),
   .res_valid(res_valid), .res_code(res_code), .res_data(res_data),
   .stall_active(stall_active), .replay(replay)
);

// File: tb/test_sqf_store_queue.sv
`timescale 1ns/1ps
module test_sqf_store_queue;
   localparam int SLOTS = 8, ADDR_W = 32, SEQ_W = 16, DB = 16, LQW = 5;
   localparam int IDX_W = 3, SIZE_W = 5, DW = 128;

   logic clk = 1'b0, rst_n = 1'b0;
   logic enq_valid = 0; logic [SEQ_W-1:0] enq_seq = '0;
   logic [IDX_W-1:0] enq_idx; logic sq_full; logic [IDX_W:0] sq_count;
   logic wr_valid = 0; logic [IDX_W-1:0] wr_idx = '0; logic [ADDR_W-1:0] wr_addr = '0;
   logic [SIZE_W-1:0] wr_size = '0; logic wr_uncached = 0; logic [DW-1:0] wr_data = '0;
   logic cmt_valid = 0; logic [IDX_W-1:0] cmt_idx = '0;
   logic wb_go = 0, wb_ready; logic [ADDR_W-1:0] wb_addr; logic [SIZE_W-1:0] wb_size;
   logic [DW-1:0] wb_data;
   logic ld_valid = 0; logic [ADDR_W-1:0] ld_addr = '0; logic [SIZE_W-1:0] ld_size = '0;
   logic [IDX_W-1:0] ld_sq_idx = '0; logic [LQW-1:0] ld_lq_idx = '0; logic [SEQ_W-1:0] ld_seq = '0;
   logic res_valid; logic [1:0] res_code; logic [DW-1:0] res_data;
   logic stall_active, replay; logic [SEQ_W-1:0] stall_store_seq; logic [LQW-1:0] stall_load_idx;

   int nvec = 0, nerr = 0;
   bit done = 0;

   always #2 clk = ~clk;

   sqf_store_queue i_sqf_store_queue (
      .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_seq(enq_seq),
      .enq_idx(enq_idx), .sq_full(sq_full), .sq_count(sq_count),
      .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_size(wr_size),
      .wr_uncached(wr_uncached), .wr_data(wr_data), .cmt_valid(cmt_valid),
      .cmt_idx(cmt_idx), .wb_go(wb_go), .wb_ready(wb_ready), .wb_addr(wb_addr),
      .wb_size(wb_size), .wb_data(wb_data), .ld_valid(ld_valid), .ld_addr(ld_addr),
      .ld_size(ld_size), .ld_sq_idx(ld_sq_idx), .ld_lq_idx(ld_lq_idx),
      .ld_seq(ld_seq), .res_valid(res_valid), .res_code(res_code),
      .res_data(res_data), .stall_active(stall_active),
      .stall_store_seq(stall_store_seq), .stall_load_idx(stall_load_idx),
      .replay(replay)
   );

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
   endtask

   task automatic enq(input logic [SEQ_W-1:0] s, output logic [IDX_W-1:0] idx);
      enq_valid = 1'b1; enq_seq = s; idx = enq_idx;
      tick(); enq_valid = 1'b0;
   endtask

   task automatic wr(input logic [IDX_W-1:0] i, input logic [ADDR_W-1:0] a,
                     input int sz, input logic unc, input logic [DW-1:0] d);
      wr_valid = 1'b1; wr_idx = i; wr_addr = a; wr_size = SIZE_W'(sz);
      wr_uncached = unc; wr_data = d;
      tick(); wr_valid = 1'b0;
   endtask

   task automatic cmt(input logic [IDX_W-1:0] i);
      cmt_valid = 1'b1; cmt_idx = i; tick(); cmt_valid = 1'b0;
   endtask

   task automatic wb_one();
      wb_go = 1'b1; tick(); wb_go = 1'b0;
   endtask

   task automatic load(input logic [ADDR_W-1:0] a, input int sz,
                       input logic [IDX_W-1:0] sqi, input logic [LQW-1:0] lqi,
                       input logic [SEQ_W-1:0] s);
      ld_valid = 1'b1; ld_addr = a; ld_size = SIZE_W'(sz);
      ld_sq_idx = sqi; ld_lq_idx = lqi; ld_seq = s;
      tick(); ld_valid = 1'b0;
   endtask

   function automatic logic [DW-1:0] pattern(input logic [7:0] base);
      logic [DW-1:0] r;
      for (int k = 0; k < DB; k++) r[k*8 +: 8] = base + 8'(k);
      return r;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog: run did not finish");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   initial begin
      logic [IDX_W-1:0] ix;
      logic [DW-1:0] dA, dB, dC, exp_d;
      logic [1:0] exp_c;
      dA = pattern(8'h10); dB = pattern(8'h50); dC = pattern(8'h90);
      do_reset();

      // reset state
      chk("R1 reset count", DW'(sq_count), 0);
      chk("R1 reset full", DW'(sq_full), 0);
      chk("R7 reset res_valid", DW'(res_valid), 0);
      chk("R8 reset stall", DW'(stall_active), 0);
      chk("R12 reset wb_ready", DW'(wb_ready), 0);

      // R2 / R1: fill, overflow, wrap
      for (int i = 0; i < SLOTS - 1; i++) begin
         enq(SEQ_W'(i), ix);
         chk("R2 enq index", DW'(ix), DW'(i));
         chk("R2 count", DW'(sq_count), DW'(i + 1));
      end
      chk("R1 full at SLOTS-1", DW'(sq_full), 1);
      enq(16'd99, ix);
      chk("R1 enq ignored idx", DW'(enq_idx), 7);
      chk("R1 enq ignored count", DW'(sq_count), 7);
      wr(3'd0, 32'h300, 4, 1'b0, dA);
      cmt(3'd0);
      wb_one();
      tick();
      chk("R11 head freed", DW'(sq_count), 6);
      chk("R1 not full", DW'(sq_full), 0);
      enq(16'd7, ix); chk("R2 idx 7", DW'(ix), 7);
      enq(16'd8, ix); chk("R2 wrap idx 0", DW'(ix), 0);
      wr(3'd7, 32'h200, 4, 1'b0, dB);
      load(32'h200, 4, 3'd0, 5'd1, 16'd50);
      chk("R3 wrap forward code", DW'(res_code), 1);
      chk("R3 wrap forward data", res_data, DW'(32'h53525150));

      // R5 / R6 sweep against a single 8-byte store at 0x100
      do_reset();
      enq(16'd10, ix);
      wr(3'd0, 32'h100, 8, 1'b0, dA);
      for (int a = 32'hF0; a < 32'h110; a++) begin
         for (int sl = 0; sl < 5; sl++) begin
            int sz, sa, ssz;
            sz = 1 << sl; sa = 32'h100; ssz = 8;
            load(ADDR_W'(a), sz, 3'd1, 5'd0, 16'd100);
            exp_d = '0;
            if (a >= sa && a + sz <= sa + ssz) begin
               int off;
               exp_c = 2'd1;
               off = a & (ssz - 1);
               for (int k = 0; k < sz; k++)
                  if (off + k < DB) exp_d[k*8 +: 8] = dA[(off + k)*8 +: 8];
            end else if (a < sa + ssz && a + sz > sa) exp_c = 2'd2;
            else exp_c = 2'd0;
            chk("R5/R6 sweep code", DW'(res_code), DW'(exp_c));
            chk("R5/R6 sweep data", res_data, exp_d);
            chk("R7 sweep valid", DW'(res_valid), 1);
         end
      end

      // ordering, skipping, stall record, writeback, replay
      do_reset();
      enq(16'd10, ix); wr(3'd0, 32'h100, 8, 1'b0, dA);
      enq(16'd11, ix); wr(3'd1, 32'h100, 4, 1'b0, dB);
      load(32'h100, 4, 3'd2, 5'd3, 16'd20);
      chk("R3 youngest wins", res_data, DW'(32'h53525150));
      load(32'h104, 4, 3'd2, 5'd3, 16'd20);
      chk("R3 older store forwards", res_data, DW'(32'h17161514));
      load(32'h102, 4, 3'd2, 5'd4, 16'd30);
      chk("R6 youngest partial stalls", DW'(res_code), 2);
      chk("R8 stall set", DW'(stall_active), 1);
      chk("R8 stall store seq", DW'(stall_store_seq), 11);
      chk("R8 stall load idx", DW'(stall_load_idx), 4);
      load(32'h102, 4, 3'd2, 5'd6, 16'd40);
      chk("R8 younger load kept out", DW'(stall_load_idx), 4);
      load(32'h102, 4, 3'd2, 5'd2, 16'd25);
      chk("R8 older load replaces", DW'(stall_load_idx), 2);
      load(32'h100, 4, 3'd1, 5'd3, 16'd20);
      chk("R3 range ends at index", res_data, DW'(32'h13121110));
      load(32'h100, 4, 3'd0, 5'd3, 16'd20);
      chk("R3 empty range misses", DW'(res_code), 0);
      enq(16'd12, ix);
      load(32'h100, 4, 3'd3, 5'd3, 16'd20);
      chk("R4 size zero skipped", res_data, DW'(32'h53525150));
      wr(3'd2, 32'h100, 4, 1'b1, dC);
      load(32'h100, 4, 3'd3, 5'd3, 16'd20);
      chk("R4 uncacheable skipped", res_data, DW'(32'h53525150));
      chk("R12 no commit no wb", DW'(wb_ready), 0);
      cmt(3'd0);
      chk("R12 commit enables wb", DW'(wb_ready), 1);
      chk("R9 wb addr", DW'(wb_addr), DW'(32'h100));
      chk("R9 wb size", DW'(wb_size), 8);
      wb_one();
      chk("R11 count before free", DW'(sq_count), 3);
      chk("R9 next slot uncommitted", DW'(wb_ready), 0);
      tick();
      chk("R11 count after free", DW'(sq_count), 2);
      load(32'h104, 4, 3'd2, 5'd3, 16'd20);
      chk("R3 written-back store excluded", DW'(res_code), 0);
      cmt(3'd1);
      chk("R9 wb data", wb_data, dB);
      wb_one();
      chk("R10 replay pulse", DW'(replay), 1);
      chk("R10 stall cleared", DW'(stall_active), 0);
      tick();
      chk("R10 replay one cycle", DW'(replay), 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule